// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a single-cycle packed integer datapath. It takes two 64-bit operands, views each as a row of independent lanes, and applies one operation to every lane at the same time. The lane size is chosen per operation: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. No carry or borrow ever crosses from one lane into the next.

The operations are wrapping add and subtract, rounding average, shift-then-add, equality and signed greater-than compares that produce lane masks, and a signed multiply that keeps the upper half of each 16-bit product. The operands, lane size, opcode and shift amount are sampled on a rising clock edge. The packed result appears on the output register one edge later.

Top module: `simd_alu`

## Requirements
- R1: `lane_sz` selects the lane width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, and 3 also means 32-bit. Lane i takes bits [i*W +: W] of each operand and writes the same bits of the result.
- R2: Lanes are independent. A carry or borrow out of one lane never changes a neighbouring lane. For example, 8-bit adds of 0xFF + 0x01 in every lane give 0x00 in every lane.
- R3: Opcode 0 gives a+b and opcode 1 gives a-b in every lane, both taken modulo 2^W.
- R4: Opcode 2 gives the rounding average (a+b+1)>>1 of the unsigned lane values, computed with one extra bit so that it never overflows. Each 8-bit result lies between the smaller and the larger input.
- R5: Opcode 3 gives (a<<s)+b modulo 2^W in each lane. Here s is `shamt` when `shamt` is 1, 2 or 3, and s is 1 when `shamt` is 0.
- R6: Opcode 4 (equal) and opcode 5 (signed a greater than signed b) set each lane to all ones when the condition holds and to all zeros when it does not.
- R7: Opcode 6 with 16-bit lanes returns bits [31:16] of the signed 32-bit product of each lane pair. With any other lane size it returns zero.
- R8: Opcodes 7 to 15 return a zero result.
- R9: `res` is registered. It shows the result of the inputs sampled at the previous rising edge, and it reads zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B |
| lane_sz | input | 2 | Lane size select |
| opcode | input | 4 | Operation select |
| shamt | input | 2 | Shift amount for shift-then-add |
| res | output | 64 | Registered packed result |

## Verification
The assertions check these properties on every cycle:
- a compare result is built only from 0x00 and 0xFF bytes;
- equal operands compared for equality give all ones;
- a multiply-high with a lane size other than 16 bits gives zero, and an undefined opcode gives zero;
- an 8-bit average in the lowest lane lies between its two inputs.

The arithmetic value of every lane, for every lane size, and the blocking of carries at lane edges can only be shown by the bench. It compares each result with a per-element model across random and directed operands.

// File: rtl/simd_alu.sv
module simd_alu #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [1:0]      lane_sz,
  input  logic [3:0]      opcode,
  input  logic [1:0]      shamt,
  output logic [XLEN-1:0] res
);
  localparam int NSZ = 3;

  logic [XLEN-1:0] by_sz [NSZ];
  logic [1:0]      sh;

  assign sh = (shamt == 2'd0) ? 2'd1 : shamt;

  for (genvar gw = 0; gw < NSZ; gw++) begin : g_w
    localparam int W = 8 << gw;
    localparam int N = XLEN / W;
    for (genvar gl = 0; gl < N; gl++) begin : g_l
      logic [W-1:0] a, b, o, mh;
      logic [W:0]   s;
      assign a = op_a[gl*W +: W];
      assign b = op_b[gl*W +: W];
      assign s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
      if (W == 16) begin : g_mul
        logic signed [2*W-1:0] p;
        assign p  = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
        assign mh = p[2*W-1:W];
      end else begin : g_nomul
        assign mh = '0;
      end
      always_comb begin
        case (opcode)
          4'd0:    o = a + b;
          4'd1:    o = a - b;
          4'd2:    o = s[W:1];
          4'd3:    o = (a << sh) + b;
          4'd4:    o = (a == b) ? '1 : '0;
          4'd5:    o = ($signed(a) > $signed(b)) ? '1 : '0;
          4'd6:    o = mh;
          default: o = '0;
        endcase
      end
      assign by_sz[gw][gl*W +: W] = o;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               res <= '0;
    else if (lane_sz == 2'd0) res <= by_sz[0];
    else if (lane_sz == 2'd1) res <= by_sz[1];
    else                      res <= by_sz[2];
  end

  function automatic logic bytes_are_mask(input logic [XLEN-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < XLEN/8; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction

  p_cmp_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(opcode) == 4'd4 || $past(opcode) == 4'd5)) |-> bytes_are_mask(res));

  p_cmp_eq_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(opcode) == 4'd4 && $past(op_a) == $past(op_b)) |-> (res == '1));

  p_mulhi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(opcode) == 4'd6 && $past(lane_sz) != 2'd1) |-> (res == '0));

  p_bad_op_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(opcode) >= 4'd7) |-> (res == '0));

  p_avg_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(opcode) == 4'd2 && $past(lane_sz) == 2'd0) |->
    ((res[7:0] >= (($past(op_a[7:0]) < $past(op_b[7:0])) ? $past(op_a[7:0]) : $past(op_b[7:0]))) &&
     (res[7:0] <= (($past(op_a[7:0]) > $past(op_b[7:0])) ? $past(op_a[7:0]) : $past(op_b[7:0])))));
endmodule

// File: tb/sim_simd_alu.sv
module sim_simd_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  lane_sz = '0;
  logic [3:0]  opcode = '0;
  logic [1:0]  shamt = '0;
  logic [63:0] res;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  simd_alu u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .lane_sz(lane_sz),
               .opcode(opcode), .shamt(shamt), .res(res));

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] ls, input logic [3:0] op,
                                        input logic [1:0] sa);
    int w, n, s;
    logic [63:0] r, m;
    w = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    n = 64 / w;
    s = (sa == 2'd0) ? 1 : int'(sa);
    m = (64'd1 << w) - 64'd1;
    r = '0;
    for (int i = 0; i < n; i++) begin
      longint unsigned x, y, e;
      longint sx, sy, p;
      x = (a >> (i*w)) & m;
      y = (b >> (i*w)) & m;
      sx = (x >= (64'd1 << (w-1))) ? longint'(x) - longint'(64'd1 << w) : longint'(x);
      sy = (y >= (64'd1 << (w-1))) ? longint'(y) - longint'(64'd1 << w) : longint'(y);
      case (op)
        4'd0: e = x + y;
        4'd1: e = x - y;
        4'd2: e = (x + y + 1) >> 1;
        4'd3: e = (x << s) + y;
        4'd4: e = (x == y) ? m : 0;
        4'd5: e = (sx > sy) ? m : 0;
        4'd6: begin p = sx * sy; e = (w == 16) ? longint'(p >>> 16) : 0; end
        default: e = 0;
      endcase
      r = r | ((e & m) << (i*w));
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic [1:0] ls);
    case (op)
      4'd0, 4'd1: return (ls == 2'd3) ? "R1" : "R3";
      4'd2:       return "R4";
      4'd3:       return "R5";
      4'd4, 4'd5: return "R6";
      4'd6:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] exp);
    checks++;
    if (res !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, res, exp);
    end
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [1:0] ls,
                     input logic [3:0] op, input logic [1:0] sa, input string tag);
    op_a = a; op_b = b; lane_sz = ls; opcode = op; shamt = sa;
    @(negedge clk);
    check(tag, model(a, b, ls, op, sa));
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h1; opcode = 4'd0;
    repeat (3) @(negedge clk);
    check("R9 reset", 64'h0);
    rst_n = 1'b1;
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 4'd0, 2'd0, "R2 carry8");
    check("R2 carry8 lit", 64'h0);
    run(64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 2'd1, 4'd1, 2'd0, "R2 borrow16");
    check("R2 borrow16 lit", 64'hFFFF_FFFF_FFFF_FFFF);
    run(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 2'd2, 4'd0, 2'd0, "R1 add32");
    check("R1 add32 lit", 64'h0000_0000_0000_0000);
    run(64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 2'd3, 4'd0, 2'd0, "R1 size3");
    run(64'hFF01_FF01_FF01_FF01, 64'hFF00_FF00_FF00_FF00, 2'd0, 4'd2, 2'd0, "R4 avgmax");
    check("R4 avgmax lit", 64'hFF01_FF01_FF01_FF01);
    run(64'h0000_0000_0000_0081, 64'h0000_0000_0000_0001, 2'd0, 4'd3, 2'd0, "R5 sh0");
    check("R5 sh0 lit", 64'h0000_0000_0000_0003);
    run(64'h0000_0000_0000_0081, 64'h0000_0000_0000_0001, 2'd0, 4'd3, 2'd3, "R5 sh3");
    run(64'h8000_7FFF_0005_0005, 64'h7FFF_8000_0005_0004, 2'd1, 4'd5, 2'd0, "R6 gt");
    check("R6 gt lit", 64'h0000_FFFF_0000_FFFF);
    run(64'h1111_2222_3333_4444, 64'h1111_2222_3333_4445, 2'd1, 4'd4, 2'd0, "R6 eq");
    run(64'h8000_7FFF_FFFF_0100, 64'h8000_7FFF_0002_0100, 2'd1, 4'd6, 2'd0, "R7 mulhi");
    check("R7 mulhi lit", 64'h4000_3FFF_FFFF_0001);
    run(64'h8000_7FFF_FFFF_0100, 64'h8000_7FFF_0002_0100, 2'd0, 4'd6, 2'd0, "R7 size8");
    run(64'h8000_7FFF_FFFF_0100, 64'h8000_7FFF_0002_0100, 2'd2, 4'd6, 2'd0, "R7 size32");
    run(64'hDEAD_BEEF_0123_4567, 64'h0BAD_F00D_89AB_CDEF, 2'd0, 4'd9, 2'd0, "R8 badop");
    for (int k = 0; k < 600; k++) begin
      logic [63:0] a, b;
      logic [1:0] ls, sa;
      logic [3:0] op;
      a = {$urandom, $urandom};
      b = ($urandom % 8 == 0) ? a : {$urandom, $urandom};
      ls = 2'($urandom);
      op = 4'($urandom % 9);
      sa = 2'($urandom);
      run(a, b, ls, op, sa, tag_of(op, ls));
    end
    rst_n = 1'b0;
    op_a = 64'h5; op_b = 64'h7; opcode = 4'd0;
    @(negedge clk);
    check("R9 reset again", 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule